// File: doc/BRIEF.md
# Smart Card Receive Sampler

This block receives character frames for a smart card from a single half-duplex data line. A basic clock enable drives its timing. That enable pulses at a fixed multiple of the bit rate, and a two-bit select input picks the multiple: 32, 64, 256 or 372. The last of these is not a power of two.

While idle, the receiver looks for a falling edge on the synchronised line, sampled on basic-clock pulses. When it finds one, it restarts its bit-period counter at that pulse and captures the ratio selection. From then on it samples each bit once, at the middle of the bit period. Each frame is one start bit, eight data bits sent LSB first, one even parity bit and a guard period. At the guard sample the block presents the byte with a one-cycle valid pulse, together with parity and framing error flags.

The state machine has six states:

- **IDLE** moves to **START** on a falling edge (transition *edge_seen*).
- **START** moves to **DATA** when the midpoint sample is low (*start_ok*). It goes back to **IDLE** when that sample is high (*glitch_drop*).
- **DATA** moves to **PARITY** after the eighth data sample (*byte_done*).
- **PARITY** moves to **GUARD** at its sample (*parity_taken*).
- **GUARD** moves to **IDLE** when its sample is high (*rearm*). It moves to **RECOVER** when that sample is low (*line_stuck*).
- **RECOVER** moves to **IDLE** at the first midpoint sample that reads high (*line_released*).

Top module: `sc_rx_sampler`

## Requirements
- R1: After reset, rx_valid, parity_err and frame_err are 0, rx_data is 0, and the receiver is idle waiting for a falling edge.
- R2: Select code 00 sets a bit period of 32 basic-clock pulses, 01 sets 64, 10 sets 372 and 11 sets 256.
- R3: Each bit is sampled on the basic-clock pulse where the in-bit count equals ratio/2 - 1. That is count 15, 31, 185 or 127, the 16th, 32nd, 186th or 128th pulse of the bit. The pulse where the edge is detected counts as 0.
- R4: In idle, a high-to-low change between two consecutive basic-clock samples of the synchronised line restarts the bit-period counter at that pulse.
- R5: If the line reads high at the start-bit midpoint sample, no character is reported and the receiver waits for a new falling edge.
- R6: A frame is start (0), eight data bits LSB first, even parity, then guard. At the guard sample, rx_valid pulses high for exactly one clock cycle, with the received byte on rx_data.
- R7: When the nine data-plus-parity bits hold an odd number of ones, parity_err is 1 in the cycle of the rx_valid pulse, and the byte is still presented. Otherwise parity_err is 0.
- R8: A low guard sample sets frame_err in the cycle of the rx_valid pulse. The receiver accepts no new start until a midpoint sample reads the line high, and it then receives the next frame normally.
- R9: A change of the select input during a frame does not alter that frame's timing. The new ratio applies from the next start edge.
- R10: The bit-period counter advances only on clock cycles where the basic clock enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_en | input | 1 | Basic clock enable, one pulse per oversampling step |
| line_in | input | 1 | Asynchronous receive data line, idle high |
| ratio_sel | input | 2 | Oversampling ratio select: 00=32, 01=64, 10=372, 11=256 |
| rx_data | output | DATA_W | Last received byte, held until the next character |
| rx_valid | output | 1 | One-cycle pulse when a character is presented |
| parity_err | output | 1 | Parity mismatch, valid with rx_valid |
| frame_err | output | 1 | Guard period sampled low, valid with rx_valid |

## Verification
Random frames cover every ratio code, random bytes and random parity corruption. Some use full-width bit levels and some use a narrow pattern, where each data and parity bit carries its true value only on the one midpoint pulse and the inverse everywhere else. The narrow pattern tells an exact midpoint sample apart from one that is early or late by a single pulse, and it runs at the 372 ratio as well as the powers of two. Directed frames add the following cases:

- a start glitch that returns high exactly at the midpoint;
- a guard period held low for a whole extra bit;
- a ratio change inside a frame followed by a frame at the new ratio;
- a slower enable cadence, which shows that the counter follows the enable and not the clock.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

    localparam int CNT_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_GUARD,
        ST_RECOVER
    } rx_state_e;

    // Bit period length in basic-clock pulses for a select code.
    function automatic logic [CNT_W-1:0] ratio_of(input logic [1:0] sel);
        logic [CNT_W-1:0] r;
        unique case (sel)
            2'b00: r = CNT_W'(32);
            2'b01: r = CNT_W'(64);
            2'b10: r = CNT_W'(372);
            default: r = CNT_W'(256);
        endcase
        return r;
    endfunction

    // In-bit count at which the midpoint sample is taken.
    function automatic logic [CNT_W-1:0] mid_of(input logic [1:0] sel);
        return (ratio_of(sel) >> 1) - CNT_W'(1);
    endfunction

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_raw,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= line_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign line_s = chain_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    prev_q <= 1'b1;
        else if (tick) prev_q <= line_s;
    end

    assign fall = tick && prev_q && !line_s;

endmodule

// File: rtl/sc_rx_bitcnt.sv
module sc_rx_bitcnt
    import sc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             run,
    input  logic [1:0]       sel,
    output logic [1:0]       sel_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             mid
);
    logic [CNT_W-1:0] last_cnt;

    assign last_cnt = ratio_of(sel_q) - CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 2'b00;
            cnt_q <= '0;
        end else if (start) begin
            sel_q <= sel;
            cnt_q <= CNT_W'(1);
        end else if (run && tick) begin
            cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    assign mid = run && tick && (cnt_q == mid_of(sel_q));

endmodule

// File: rtl/sc_rx_shift.sv
module sc_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] data,
    output logic         par
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            par  <= 1'b0;
        end else if (clear) begin
            data <= '0;
            par  <= 1'b0;
        end else if (shift_en) begin
            data <= {bit_in, data[W-1:1]};
            par  <= par ^ bit_in;
        end
    end
endmodule

// File: rtl/sc_rx_sampler.sv
module sc_rx_sampler
    import sc_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_en,
    input  logic              line_in,
    input  logic [1:0]        ratio_sel,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              parity_err,
    output logic              frame_err
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         state_q, state_d;
    logic              line_s, fall, start, run, mid_hit;
    logic [1:0]        ratio_sel_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic [DATA_W-1:0] shreg;
    logic              par_acc, perr_q, shift_en;

    assign start    = fall && (state_q == ST_IDLE);
    assign run      = (state_q != ST_IDLE);
    assign shift_en = (state_q == ST_DATA) && mid_hit;

    sc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bclk_en),
        .line_raw (line_in),
        .line_s   (line_s),
        .fall     (fall)
    );

    sc_rx_bitcnt u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bclk_en),
        .start (start),
        .run   (run),
        .sel   (ratio_sel),
        .sel_q (ratio_sel_q),
        .cnt_q (cnt_q),
        .mid   (mid_hit)
    );

    sc_rx_shift #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .shift_en (shift_en),
        .bit_in   (line_s),
        .data     (shreg),
        .par      (par_acc)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (fall) state_d = ST_START;
            ST_START:   if (mid_hit) state_d = line_s ? ST_IDLE : ST_DATA;
            ST_DATA:    if (mid_hit && (bit_idx_q == IDX_W'(DATA_W-1))) state_d = ST_PARITY;
            ST_PARITY:  if (mid_hit) state_d = ST_GUARD;
            ST_GUARD:   if (mid_hit) state_d = line_s ? ST_IDLE : ST_RECOVER;
            ST_RECOVER: if (mid_hit && line_s) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Bit index and parity result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx_q <= '0;
            perr_q    <= 1'b0;
        end else begin
            if (start)
                bit_idx_q <= '0;
            else if (shift_en)
                bit_idx_q <= bit_idx_q + IDX_W'(1);
            if ((state_q == ST_PARITY) && mid_hit)
                perr_q <= par_acc ^ line_s;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            if ((state_q == ST_GUARD) && mid_hit) begin
                rx_valid   <= 1'b1;
                rx_data    <= shreg;
                parity_err <= perr_q;
                frame_err  <= !line_s;
            end
        end
    end

endmodule

// File: rtl/sc_rx_sampler_chk.sv
module sc_rx_sampler_chk
    import sc_rx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             rx_valid,
    input logic             parity_err,
    input logic             frame_err,
    input rx_state_e        state_q,
    input logic [1:0]       sel_q,
    input logic [CNT_W-1:0] cnt_q
);
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    valid_after_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(state_q) == ST_GUARD));

    // R7
    perr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> rx_valid);

    // R8
    ferr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> rx_valid);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio_of(sel_q));

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE)) |-> $stable(sel_q));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

endmodule

bind sc_rx_sampler sc_rx_sampler_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (bclk_en),
    .rx_valid   (rx_valid),
    .parity_err (parity_err),
    .frame_err  (frame_err),
    .state_q    (state_q),
    .sel_q      (ratio_sel_q),
    .cnt_q      (cnt_q)
);

// File: tb/test_sc_rx_sampler.sv
module test_sc_rx_sampler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_en = 1'b0;
    logic       line_in = 1'b1;
    logic [1:0] ratio_sel = 2'b00;
    logic [7:0] rx_data;
    logic       rx_valid, parity_err, frame_err;

    int n_checks = 0;
    int n_fail   = 0;
    int tdiv     = 3;
    int divc     = 0;
    int cycles   = 0;

    int         vcount = 0;
    logic [7:0] got_data = 8'h00;
    logic       got_perr = 1'b0;
    logic       got_ferr = 1'b0;

    sc_rx_sampler i_sc_rx_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_en    (bclk_en),
        .line_in    (line_in),
        .ratio_sel  (ratio_sel),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .parity_err (parity_err),
        .frame_err  (frame_err)
    );

    always #10 clk = ~clk;

    // Basic clock enable: one pulse every tdiv clocks
    always @(negedge clk) begin
        divc    = (divc + 1 >= tdiv) ? 0 : divc + 1;
        bclk_en = (divc == 0);
    end

    // Output monitor
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            vcount   = vcount + 1;
            got_data = rx_data;
            got_perr = parity_err;
            got_ferr = frame_err;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 195000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic int ratio_f(input logic [1:0] s);
        case (s)
            2'b00: return 32;
            2'b01: return 64;
            2'b10: return 372;
            default: return 256;
        endcase
    endfunction

    function automatic logic bit_val(input int b, input logic [7:0] d, input logic pflip, input int glow);
        if (b == 0) return 1'b0;
        if (b <= 8) return d[b-1];
        if (b == 9) return (^d) ^ pflip;
        if (b < 10 + glow) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!bclk_en);
        @(negedge clk);
    endtask

    task automatic idle_ticks(input int n);
        line_in = 1'b1;
        for (int k = 0; k < n; k++) wait_tick();
    endtask

    // Drive one frame; value for in-frame count j is presented so it is seen at tick j.
    task automatic send_frame(input logic [1:0] sel, input logic [7:0] d, input logic pflip,
                              input logic narrow, input int glow, input logic glitch,
                              input int chg_at, input logic [1:0] sel2);
        int n, mid, total;
        n     = ratio_f(sel);
        mid   = n / 2 - 1;
        total = glitch ? 2 * n : (11 + glow) * n;
        ratio_sel = sel;
        idle_ticks(4);
        for (int j = 0; j < total; j++) begin
            int   b, pos;
            logic v;
            b   = j / n;
            pos = j % n;
            if (glitch) v = !((b == 0) && (pos < mid));
            else begin
                v = bit_val(b, d, pflip, glow);
                if (narrow && b >= 1 && b <= 9 && pos != mid) v = ~v;
            end
            if (j == chg_at) ratio_sel = sel2;
            wait_tick();
            line_in = v;
        end
        idle_ticks(4);
    endtask

    task automatic expect_char(input string req, input int v0, input logic [7:0] d,
                               input logic perr, input logic ferr);
        check(vcount - v0 == 1, req, vcount - v0, 1);
        check(got_data == d, req, got_data, d);
        check(got_perr == perr, req, got_perr, perr);
        check(got_ferr == ferr, req, got_ferr, ferr);
    endtask

    initial begin
        int v0;
        void'($urandom(32'h5C1D_0E47));
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        check(parity_err == 1'b0 && frame_err == 1'b0, "R1 flags", {parity_err, frame_err}, 0);
        check(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
        rst_n = 1'b1;
        idle_ticks(8);
        check(vcount == 0, "R1 idle no output", vcount, 0);

        // R6 / R2: basic frame at ratio 32
        v0 = vcount;
        send_frame(2'b00, 8'hA5, 1'b0, 1'b0, 0, 1'b0, -1, 2'b00);
        expect_char("R6 frame ratio32", v0, 8'hA5, 1'b0, 1'b0);

        // R3 / R2 / R10: exact midpoint at ratio 372 with narrow bits
        v0 = vcount;
        send_frame(2'b10, 8'h3C, 1'b0, 1'b1, 0, 1'b0, -1, 2'b00);
        expect_char("R3 narrow ratio372", v0, 8'h3C, 1'b0, 1'b0);

        // R7: parity error at ratio 64, byte still presented
        v0 = vcount;
        send_frame(2'b01, 8'h96, 1'b1, 1'b1, 0, 1'b0, -1, 2'b00);
        expect_char("R7 parity error", v0, 8'h96, 1'b1, 1'b0);

        // R5: start glitch, then R4 resynchronisation
        v0 = vcount;
        send_frame(2'b00, 8'h00, 1'b0, 1'b0, 0, 1'b1, -1, 2'b00);
        check(vcount == v0, "R5 glitch no char", vcount - v0, 0);
        v0 = vcount;
        send_frame(2'b00, 8'h81, 1'b0, 1'b1, 0, 1'b0, -1, 2'b00);
        expect_char("R4 frame after glitch", v0, 8'h81, 1'b0, 1'b0);

        // R8: guard held low for an extra bit at ratio 256
        v0 = vcount;
        send_frame(2'b11, 8'h5A, 1'b0, 1'b1, 1, 1'b0, -1, 2'b00);
        expect_char("R8 framing error", v0, 8'h5A, 1'b0, 1'b1);
        v0 = vcount;
        send_frame(2'b00, 8'h7E, 1'b0, 1'b1, 0, 1'b0, -1, 2'b00);
        expect_char("R8 rearm after recover", v0, 8'h7E, 1'b0, 1'b0);

        // R9: select changes mid-frame, applies only to the next frame
        v0 = vcount;
        send_frame(2'b01, 8'hC3, 1'b0, 1'b1, 0, 1'b0, 150, 2'b00);
        expect_char("R9 old ratio kept", v0, 8'hC3, 1'b0, 1'b0);
        v0 = vcount;
        send_frame(2'b00, 8'h18, 1'b0, 1'b1, 0, 1'b0, -1, 2'b00);
        expect_char("R9 new ratio used", v0, 8'h18, 1'b0, 1'b0);

        // R10: slower enable cadence
        tdiv = 5;
        v0 = vcount;
        send_frame(2'b01, 8'hE7, 1'b0, 1'b1, 0, 1'b0, -1, 2'b00);
        expect_char("R10 slow enable", v0, 8'hE7, 1'b0, 1'b0);
        tdiv = 3;

        // R2 / R3 / R6 / R7: random frames
        for (int k = 0; k < 12; k++) begin
            logic [1:0] s;
            logic [7:0] d;
            logic       pf, nw;
            s  = 2'($urandom % 4);
            d  = 8'($urandom);
            pf = (($urandom % 4) == 0);
            nw = 1'($urandom);
            v0 = vcount;
            send_frame(s, d, pf, nw, 0, 1'b0, -1, 2'b00);
            expect_char("R2 random frame", v0, d, pf, 1'b0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule